// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block sits between a host processor and an auxiliary system microcontroller and carries short commands from one to the other. The host sees a small word-addressed register window on a simple 32-bit bus: it stages up to four input words, optionally sets two pointer words, and then writes a command word. That single write is the only thing that starts a transaction. It latches the command, marks the mailbox busy and sends a one-cycle request pulse to the controller.

The controller sees the latched command word, the staged input words and the pointer words. When it has finished, it presents up to four result words, an error flag and an 8-bit error code, together with a one-cycle completion strobe. The mailbox stores these values, clears busy and, if the command asked for it, pulses a completion interrupt to the host. The host polls the status word until busy is clear and reads the result words only when the error bit is 0.

A command write that arrives while a transaction is still open is dropped. The drop is recorded in a sticky flag that the controller can see. The meaning of the individual command codes is left to the controller firmware. Typical codes are the reset family 0xF0 to 0xF3, the firmware revision query 0xF4 and the watchdog threshold 0xF8.

Top module: `hcm_mailbox`

## Requirements
- R1: After a synchronous reset, busy, error, error code, the latched command, the pointers, both buffers, the overrun flag and both interrupts are all 0. The status word then reads as the initiator id in bits 15:8 and 0 everywhere else.
- R2: A host write to byte address 0x00 while not busy latches the whole data word onto `ctl_cmd_word`. It also raises `ctl_cmd_irq` for exactly the one cycle after the write edge. The command word layout is code in 7:0, completion-interrupt request in bit 8, sub-command id in 15:12 and input word count in 23:16.
- R3: Starting from the edge that accepts a command, the status word at 0x04 shows busy (bit 0) as 1, error (bit 1) as 0 and error code (bits 23:16) as 0, and its bits 7:4 show bits 15:12 of the command.
- R4: A command write while busy changes neither the latched command nor the status and raises no request pulse. It sets `ctl_overrun`, which stays set until reset.
- R5: A `ctl_done` strobe while busy clears busy and stores `ctl_err` into status bit 1 and `ctl_err_code` into status bits 23:16. On the same edge it copies the four `ctl_rbuf_flat` words (word k in bits 32k+31:32k) into the read buffer at 0x90 + 4k.
- R6: `host_done_irq` pulses for the one cycle after an accepted completion if bit 8 of the latched command is 1, and stays 0 otherwise.
- R7: A `ctl_done` strobe while not busy has no effect on the status, the read buffer or `host_done_irq`.
- R8: Write-buffer word k at 0x80 + 4k and the pointer words at 0x08 and 0x0C can be both written and read by the host. Their values appear on `ctl_wbuf_flat` (word k in bits 32k+31:32k), `ctl_sptr` and `ctl_dptr`.
- R9: Reads of 0x00, of the reserved range 0x10 to 0x7F, of any address above the read buffer and of any unaligned address return 0. Host writes to the status word, the read buffer or a reserved address have no effect.
- R10: Status bits 15:8 always hold the INIT_ID parameter (0xA5 by default), and status bits 3:2 and 31:24 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | ADDR_W | Host byte address |
| host_we | input | 1 | Host write enable |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational from address) |
| host_done_irq | output | 1 | Completion interrupt pulse to the host |
| ctl_cmd_irq | output | 1 | Command-pending pulse to the controller |
| ctl_cmd_word | output | 32 | Latched command word |
| ctl_wbuf_flat | output | 32*NBUF | Write-buffer words, packed |
| ctl_sptr | output | 32 | Source pointer word |
| ctl_dptr | output | 32 | Destination pointer word |
| ctl_overrun | output | 1 | Sticky flag for a dropped command write |
| ctl_done | input | 1 | Completion strobe from the controller |
| ctl_err | input | 1 | Completion error flag |
| ctl_err_code | input | 8 | Completion error code |
| ctl_rbuf_flat | input | 32*NBUF | Result words, packed |

## Verification
The properties assume that the controller asserts `ctl_done` for a single cycle per transaction and that every host access is a single-cycle write or a plain read with no wait states. The stimulus keeps to this. Each completion is one strobe cycle. Commands are issued only through whole-word writes at aligned addresses, apart from deliberate writes made while busy and strobes sent while idle, which the properties cover on purpose. A behavioural model of the register window follows every edge, and its outputs are compared with the design on the falling edge.

// File: rtl/hcm_pkg.sv
package hcm_pkg;

    localparam int DATA_W  = 32;
    localparam int WB_BASE = 32;   // word index of the first write-buffer word (byte 0x80)

    // Typical command codes handled by the controller firmware
    localparam logic [7:0] CODE_WARM_RST  = 8'hF0;
    localparam logic [7:0] CODE_COLD_RST  = 8'hF1;
    localparam logic [7:0] CODE_SOFT_RST  = 8'hF2;
    localparam logic [7:0] CODE_COLD_BOOT = 8'hF3;
    localparam logic [7:0] CODE_FW_REV    = 8'hF4;
    localparam logic [7:0] CODE_WDT_THR   = 8'hF8;

    typedef struct packed {
        logic [7:0] rsv_hi;
        logic [7:0] size;
        logic [3:0] sub;
        logic [2:0] rsv_lo;
        logic       ioc;
        logic [7:0] code;
    } cmd_word_t;

    typedef struct packed {
        logic [7:0] rsv_hi;
        logic [7:0] err_code;
        logic [7:0] initiator;
        logic [3:0] cmd_id;
        logic [1:0] rsv_lo;
        logic       err;
        logic       busy;
    } stat_word_t;

    typedef enum logic [2:0] {
        RG_CMD,
        RG_STAT,
        RG_SPTR,
        RG_DPTR,
        RG_WBUF,
        RG_RBUF,
        RG_RSVD
    } region_e;

    function automatic logic [DATA_W-1:0] pack_status(
        input logic       busy,
        input logic       err,
        input logic [7:0] err_code,
        input logic [7:0] initiator,
        input logic [3:0] cmd_id
    );
        stat_word_t s;
        s.rsv_hi    = '0;
        s.err_code  = err_code;
        s.initiator = initiator;
        s.cmd_id    = cmd_id;
        s.rsv_lo    = '0;
        s.err       = err;
        s.busy      = busy;
        return s;
    endfunction

endpackage

// File: rtl/hcm_addr_dec.sv
module hcm_addr_dec
    import hcm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NBUF   = 4,
    localparam int IDX_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic [ADDR_W-1:0] addr_i,
    output region_e           region_o,
    output logic [IDX_W-1:0]  idx_o
);

    localparam int RB_BASE = WB_BASE + NBUF;

    int wi;

    always_comb begin
        region_o = RG_RSVD;
        idx_o    = '0;
        wi       = int'(addr_i[ADDR_W-1:2]);
        if (addr_i[1:0] == 2'b00) begin
            if (wi == 0) begin
                region_o = RG_CMD;
            end else if (wi == 1) begin
                region_o = RG_STAT;
            end else if (wi == 2) begin
                region_o = RG_SPTR;
            end else if (wi == 3) begin
                region_o = RG_DPTR;
            end else if (wi >= WB_BASE && wi < WB_BASE + NBUF) begin
                region_o = RG_WBUF;
                idx_o    = IDX_W'(wi - WB_BASE);
            end else if (wi >= RB_BASE && wi < RB_BASE + NBUF) begin
                region_o = RG_RBUF;
                idx_o    = IDX_W'(wi - RB_BASE);
            end
        end
    end

endmodule

// File: rtl/hcm_cmd_ctrl.sv
module hcm_cmd_ctrl
    import hcm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              done_i,
    input  logic              done_err_i,
    input  logic [7:0]        done_code_i,
    output logic              busy_o,
    output logic              err_o,
    output logic [7:0]        err_code_o,
    output cmd_word_t         cmd_o,
    output logic              cmd_irq_o,
    output logic              done_irq_o,
    output logic              overrun_o,
    output logic              rbuf_load_o
);

    cmd_word_t  cmd_q;
    logic       busy_q;
    logic       err_q;
    logic [7:0] code_q;
    logic       cmd_irq_q;
    logic       done_irq_q;
    logic       ovr_q;
    logic       accept;
    logic       complete;

    assign accept   = cmd_wr_i && !busy_q;
    assign complete = done_i && busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q      <= '0;
            busy_q     <= 1'b0;
            err_q      <= 1'b0;
            code_q     <= '0;
            cmd_irq_q  <= 1'b0;
            done_irq_q <= 1'b0;
            ovr_q      <= 1'b0;
        end else begin
            cmd_irq_q  <= 1'b0;
            done_irq_q <= 1'b0;
            if (cmd_wr_i && busy_q) begin
                ovr_q <= 1'b1;
            end
            if (accept) begin
                cmd_q     <= cmd_word_t'(wdata_i);
                busy_q    <= 1'b1;
                err_q     <= 1'b0;
                code_q    <= '0;
                cmd_irq_q <= 1'b1;
            end
            if (complete) begin
                busy_q     <= 1'b0;
                err_q      <= done_err_i;
                code_q     <= done_code_i;
                done_irq_q <= cmd_q.ioc;
            end
        end
    end

    assign busy_o      = busy_q;
    assign err_o       = err_q;
    assign err_code_o  = code_q;
    assign cmd_o       = cmd_q;
    assign cmd_irq_o   = cmd_irq_q;
    assign done_irq_o  = done_irq_q;
    assign overrun_o   = ovr_q;
    assign rbuf_load_o = complete;

endmodule

// File: rtl/hcm_buf_bank.sv
module hcm_buf_bank
    import hcm_pkg::*;
#(
    parameter int NBUF   = 4,
    localparam int IDX_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   we_i,
    input  region_e                region_i,
    input  logic [IDX_W-1:0]       idx_i,
    input  logic [DATA_W-1:0]      wdata_i,
    input  logic                   rbuf_load_i,
    input  logic [NBUF*DATA_W-1:0] rbuf_in_i,
    output logic [NBUF*DATA_W-1:0] wbuf_o,
    output logic [NBUF*DATA_W-1:0] rbuf_o,
    output logic [DATA_W-1:0]      sptr_o,
    output logic [DATA_W-1:0]      dptr_o
);

    logic [DATA_W-1:0] sptr_q;
    logic [DATA_W-1:0] dptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sptr_q <= '0;
            dptr_q <= '0;
        end else if (we_i) begin
            if (region_i == RG_SPTR) sptr_q <= wdata_i;
            if (region_i == RG_DPTR) dptr_q <= wdata_i;
        end
    end

    assign sptr_o = sptr_q;
    assign dptr_o = dptr_q;

    for (genvar k = 0; k < NBUF; k++) begin : g_word
        logic [DATA_W-1:0] wb_q;
        logic [DATA_W-1:0] rb_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                wb_q <= '0;
            end else if (we_i && region_i == RG_WBUF && int'(idx_i) == k) begin
                wb_q <= wdata_i;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                rb_q <= '0;
            end else if (rbuf_load_i) begin
                rb_q <= rbuf_in_i[k*DATA_W +: DATA_W];
            end
        end

        assign wbuf_o[k*DATA_W +: DATA_W] = wb_q;
        assign rbuf_o[k*DATA_W +: DATA_W] = rb_q;
    end

endmodule

// File: rtl/hcm_mailbox.sv
module hcm_mailbox
    import hcm_pkg::*;
#(
    parameter int         ADDR_W  = 8,
    parameter int         NBUF    = 4,
    parameter logic [7:0] INIT_ID = 8'hA5
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [ADDR_W-1:0]      host_addr,
    input  logic                   host_we,
    input  logic [31:0]            host_wdata,
    output logic [31:0]            host_rdata,
    output logic                   host_done_irq,
    output logic                   ctl_cmd_irq,
    output logic [31:0]            ctl_cmd_word,
    output logic [NBUF*32-1:0]     ctl_wbuf_flat,
    output logic [31:0]            ctl_sptr,
    output logic [31:0]            ctl_dptr,
    output logic                   ctl_overrun,
    input  logic                   ctl_done,
    input  logic                   ctl_err,
    input  logic [7:0]             ctl_err_code,
    input  logic [NBUF*32-1:0]     ctl_rbuf_flat
);

    localparam int IDX_W = (NBUF > 1) ? $clog2(NBUF) : 1;

    region_e             region;
    logic [IDX_W-1:0]    idx;
    logic                busy_w;
    logic                err_w;
    logic [7:0]          code_w;
    cmd_word_t           cmd_w;
    logic                rbuf_load;
    logic [NBUF*32-1:0]  rbuf_w;

    hcm_addr_dec #(
        .ADDR_W (ADDR_W),
        .NBUF   (NBUF)
    ) u_dec (
        .addr_i   (host_addr),
        .region_o (region),
        .idx_o    (idx)
    );

    hcm_cmd_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .cmd_wr_i    (host_we && region == RG_CMD),
        .wdata_i     (host_wdata),
        .done_i      (ctl_done),
        .done_err_i  (ctl_err),
        .done_code_i (ctl_err_code),
        .busy_o      (busy_w),
        .err_o       (err_w),
        .err_code_o  (code_w),
        .cmd_o       (cmd_w),
        .cmd_irq_o   (ctl_cmd_irq),
        .done_irq_o  (host_done_irq),
        .overrun_o   (ctl_overrun),
        .rbuf_load_o (rbuf_load)
    );

    hcm_buf_bank #(
        .NBUF (NBUF)
    ) u_bank (
        .clk         (clk),
        .rst         (rst),
        .we_i        (host_we),
        .region_i    (region),
        .idx_i       (idx),
        .wdata_i     (host_wdata),
        .rbuf_load_i (rbuf_load),
        .rbuf_in_i   (ctl_rbuf_flat),
        .wbuf_o      (ctl_wbuf_flat),
        .rbuf_o      (rbuf_w),
        .sptr_o      (ctl_sptr),
        .dptr_o      (ctl_dptr)
    );

    assign ctl_cmd_word = cmd_w;

    always_comb begin
        unique case (region)
            RG_STAT: host_rdata = pack_status(busy_w, err_w, code_w, INIT_ID, cmd_w.sub);
            RG_SPTR: host_rdata = ctl_sptr;
            RG_DPTR: host_rdata = ctl_dptr;
            RG_WBUF: host_rdata = ctl_wbuf_flat[int'(idx)*32 +: 32];
            RG_RBUF: host_rdata = rbuf_w[int'(idx)*32 +: 32];
            default: host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/hcm_mailbox_chk.sv
module hcm_mailbox_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] host_addr,
    input logic              host_we,
    input logic [31:0]       host_wdata,
    input logic              busy,
    input logic              ctl_cmd_irq,
    input logic [31:0]       ctl_cmd_word,
    input logic              ctl_overrun,
    input logic              ctl_done,
    input logic              host_done_irq
);

    logic cmd_hit;
    assign cmd_hit = host_we && (host_addr == '0);

    AST_CMD_LATCH: assert property (@(posedge clk) disable iff (rst)
        (cmd_hit && !busy) |=> (ctl_cmd_irq && ctl_cmd_word == $past(host_wdata))); // R2

    AST_CMD_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
        (cmd_hit && !busy) |=> busy); // R3

    AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (cmd_hit && busy) |=> (ctl_overrun && !ctl_cmd_irq && $stable(ctl_cmd_word))); // R4

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        ctl_overrun |=> ctl_overrun); // R4

    AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (rst)
        (ctl_done && busy) |=> !busy); // R5

    AST_NO_IRQ_WITHOUT_REQ: assert property (@(posedge clk) disable iff (rst)
        (ctl_done && busy && !ctl_cmd_word[8]) |=> !host_done_irq); // R6

    AST_IDLE_DONE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (ctl_done && !busy) |=> !host_done_irq); // R7

endmodule

bind hcm_mailbox hcm_mailbox_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .host_addr     (host_addr),
    .host_we       (host_we),
    .host_wdata    (host_wdata),
    .busy          (busy_w),
    .ctl_cmd_irq   (ctl_cmd_irq),
    .ctl_cmd_word  (ctl_cmd_word),
    .ctl_overrun   (ctl_overrun),
    .ctl_done      (ctl_done),
    .host_done_irq (host_done_irq)
);

// File: tb/hcm_mailbox_tb.sv
`timescale 1ns/1ps
module hcm_mailbox_tb_top;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [7:0]   host_addr = '0;
    logic         host_we = 1'b0;
    logic [31:0]  host_wdata = '0;
    logic [31:0]  host_rdata;
    logic         host_done_irq;
    logic         ctl_cmd_irq;
    logic [31:0]  ctl_cmd_word;
    logic [127:0] ctl_wbuf_flat;
    logic [31:0]  ctl_sptr;
    logic [31:0]  ctl_dptr;
    logic         ctl_overrun;
    logic         ctl_done = 1'b0;
    logic         ctl_err = 1'b0;
    logic [7:0]   ctl_err_code = '0;
    logic [127:0] ctl_rbuf_flat = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    hcm_mailbox dut_i (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_we(host_we),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_done_irq(host_done_irq), .ctl_cmd_irq(ctl_cmd_irq),
        .ctl_cmd_word(ctl_cmd_word), .ctl_wbuf_flat(ctl_wbuf_flat),
        .ctl_sptr(ctl_sptr), .ctl_dptr(ctl_dptr), .ctl_overrun(ctl_overrun),
        .ctl_done(ctl_done), .ctl_err(ctl_err), .ctl_err_code(ctl_err_code),
        .ctl_rbuf_flat(ctl_rbuf_flat)
    );

    // behavioural reference model
    logic        m_busy, m_err, m_ovr, m_cmd_irq, m_done_irq;
    logic [7:0]  m_code;
    logic [31:0] m_cmd, m_sptr, m_dptr;
    logic [31:0] m_wbuf [4];
    logic [31:0] m_rbuf [4];

    always @(posedge clk) begin
        int w;
        w = int'(host_addr) / 4;
        if (rst) begin
            m_busy = 0; m_err = 0; m_ovr = 0; m_cmd_irq = 0; m_done_irq = 0;
            m_code = 0; m_cmd = 0; m_sptr = 0; m_dptr = 0;
            for (int i = 0; i < 4; i++) begin m_wbuf[i] = 0; m_rbuf[i] = 0; end
        end else begin
            bit take, fin;
            m_cmd_irq = 0;
            m_done_irq = 0;
            take = host_we && host_addr == 8'h00 && !m_busy;
            fin  = ctl_done && m_busy;
            if (host_we && host_addr == 8'h00 && m_busy) m_ovr = 1;
            if (host_we && host_addr[1:0] == 2'b00) begin
                if (w == 2) m_sptr = host_wdata;
                if (w == 3) m_dptr = host_wdata;
                if (w >= 32 && w < 36) m_wbuf[w-32] = host_wdata;
            end
            if (fin) begin
                m_busy = 0; m_err = ctl_err; m_code = ctl_err_code;
                m_done_irq = m_cmd[8];
                for (int i = 0; i < 4; i++) m_rbuf[i] = ctl_rbuf_flat[i*32 +: 32];
            end
            if (take) begin
                m_cmd = host_wdata; m_busy = 1; m_err = 0; m_code = 0; m_cmd_irq = 1;
            end
        end
    end

    function automatic logic [31:0] m_read(input logic [7:0] a);
        int w;
        w = int'(a) / 4;
        if (a[1:0] != 2'b00) return 32'h0;
        if (w == 1) return {8'h00, m_code, 8'hA5, m_cmd[15:12], 2'b00, m_err, m_busy};
        if (w == 2) return m_sptr;
        if (w == 3) return m_dptr;
        if (w >= 32 && w < 36) return m_wbuf[w-32];
        if (w >= 36 && w < 40) return m_rbuf[w-36];
        return 32'h0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic compare_cycle();
        logic [127:0] wb;
        for (int i = 0; i < 4; i++) wb[i*32 +: 32] = m_wbuf[i];
        chk("R2 ctl_cmd_irq", {31'b0, ctl_cmd_irq}, {31'b0, m_cmd_irq});
        chk("R2 ctl_cmd_word", ctl_cmd_word, m_cmd);
        chk("R6 host_done_irq", {31'b0, host_done_irq}, {31'b0, m_done_irq});
        chk("R4 ctl_overrun", {31'b0, ctl_overrun}, {31'b0, m_ovr});
        chk("R8 ctl_sptr", ctl_sptr, m_sptr);
        chk("R8 ctl_dptr", ctl_dptr, m_dptr);
        for (int i = 0; i < 4; i++) chk("R8 ctl_wbuf_flat", ctl_wbuf_flat[i*32 +: 32], wb[i*32 +: 32]);
        chk("R9 host_rdata", host_rdata, m_read(host_addr));
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare_cycle();
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        host_addr = a; host_we = 1'b1; host_wdata = d;
        tick();
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        host_addr = a; host_we = 1'b0;
        #1;
        chk(tag, host_rdata, exp);
    endtask

    task automatic finish_cmd(input logic e, input logic [7:0] code, input logic [127:0] rb);
        ctl_done = 1'b1; ctl_err = e; ctl_err_code = code; ctl_rbuf_flat = rb;
        tick();
        ctl_done = 1'b0; ctl_err = 1'b0; ctl_err_code = '0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1 / R10 reset state
        rd(8'h04, 32'h0000A500, "R1 R10 status after reset");
        chk("R1 command word after reset", ctl_cmd_word, 32'h0);
        chk("R1 overrun after reset", {31'b0, ctl_overrun}, 32'h0);

        // R8 staging words and pointers
        wr(8'h80, 32'h11110000);
        wr(8'h84, 32'h22220001);
        wr(8'h88, 32'h33330002);
        wr(8'h8C, 32'h44440003);
        wr(8'h08, 32'hCAFE0008);
        wr(8'h0C, 32'hBEEF000C);
        rd(8'h84, 32'h22220001, "R8 write-buffer readback");
        chk("R8 wbuf word 3 on controller side", ctl_wbuf_flat[127:96], 32'h44440003);
        rd(8'h08, 32'hCAFE0008, "R8 source pointer readback");
        rd(8'h0C, 32'hBEEF000C, "R8 destination pointer readback");

        // R2 / R3 accepted command with completion interrupt request
        wr(8'h00, 32'h000351F4);
        chk("R2 request pulse", {31'b0, ctl_cmd_irq}, 32'h1);
        chk("R2 latched word", ctl_cmd_word, 32'h000351F4);
        rd(8'h04, 32'h0000A551, "R3 busy status with id");
        tick();
        chk("R2 request pulse ends", {31'b0, ctl_cmd_irq}, 32'h0);

        // R4 write while busy
        wr(8'h00, 32'h000000F8);
        chk("R4 word kept", ctl_cmd_word, 32'h000351F4);
        chk("R4 overrun set", {31'b0, ctl_overrun}, 32'h1);
        chk("R4 no request pulse", {31'b0, ctl_cmd_irq}, 32'h0);

        // R5 / R6 completion with error
        finish_cmd(1'b1, 8'h3C, {32'hD0D0D0D3, 32'hC0C0C0C2, 32'hB0B0B0B1, 32'hA0A0A0A0});
        chk("R6 completion interrupt", {31'b0, host_done_irq}, 32'h1);
        rd(8'h04, 32'h003CA552, "R5 status after error completion");
        rd(8'h90, 32'hA0A0A0A0, "R5 result word 0");
        rd(8'h9C, 32'hD0D0D0D3, "R5 result word 3");
        tick();
        chk("R6 interrupt pulse ends", {31'b0, host_done_irq}, 32'h0);

        // R3 error cleared by new command, R6 no interrupt without request
        wr(8'h00, 32'h000020F0);
        rd(8'h04, 32'h0000A521, "R3 error cleared on accept");
        tick();
        finish_cmd(1'b0, 8'h00, {32'h4, 32'h3, 32'h2, 32'h1});
        chk("R6 no interrupt without request", {31'b0, host_done_irq}, 32'h0);
        rd(8'h04, 32'h0000A520, "R5 status after clean completion");

        // R7 strobe while idle
        finish_cmd(1'b1, 8'h77, {32'h9, 32'h9, 32'h9, 32'h9});
        chk("R7 no interrupt when idle", {31'b0, host_done_irq}, 32'h0);
        rd(8'h04, 32'h0000A520, "R7 status unchanged");
        rd(8'h90, 32'h00000001, "R7 result unchanged");

        // R9 reserved and read-only addresses
        wr(8'h10, 32'hFFFFFFFF);
        rd(8'h10, 32'h0, "R9 reserved read");
        wr(8'h04, 32'hFFFFFFFF);
        rd(8'h04, 32'h0000A520, "R9 status write ignored");
        wr(8'h94, 32'h55555555);
        rd(8'h94, 32'h00000002, "R9 result write ignored");
        rd(8'h00, 32'h0, "R9 command reads zero");
        rd(8'hA0, 32'h0, "R9 beyond result buffer");
        rd(8'h81, 32'h0, "R9 unaligned read");
        chk("R4 overrun still set", {31'b0, ctl_overrun}, 32'h1);
        chk("R10 reserved status bits", {24'b0, host_rdata[31:24]}, 32'h0);

        tick();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule